// File: doc/BRIEF.md
# Clock Output Mode Controller

This block sets the operating mode of a multi-output clock generator from three static select pins, one CPU-rate select bit and two frequency bits. It then steers six output groups: CPU (true/complement pair), memory reference (a pair of single-ended outputs in opposite phase), 66 MHz, PCI, 48 MHz and crystal reference. In the two active modes each group passes a clock that comes from outside the block. The memory reference group takes either its own half-rate source or the 66 MHz source, depending on the CPU rate. In tristate and reserved modes every group is disabled and held low. In test mode the block derives each group from the test clock, with a fixed divider for each group.

A new select code takes effect only after it has held steady for a set number of test-clock cycles, so a glitch on the pins cannot disturb the outputs. A reserved code sets a sticky flag that only reset clears. An active-low spread request is passed to the groups that can spread, and only in the active modes.

Top module: `clkmode_ctrl`

## Requirements
- R1: The select code is {cpu_fast_i, freq_bits_i[0], freq_bits_i[1]}. 000 selects the 100 MHz active mode (mode_o=0), 100 the 133 MHz active mode (mode_o=1), 011 tristate (mode_o=2) and 111 test (mode_o=3). The codes 001, 010, 101 and 110 are reserved (mode_o=4). While reset is held, mode_o is 2.
- R2: A changed select code appears on mode_o after the third rising test-clock edge that samples it, counted from the first such edge, provided it holds steady through all three. A code that lasts fewer cycles leaves mode_o unchanged.
- R3: In the 100 MHz active mode, oe_o is 6'h3F. The output of each group follows its source input. The bit index of each group in oe_o and spread_o is: 0 CPU, 1 memory reference, 2 66 MHz, 3 PCI, 4 48 MHz, 5 crystal reference.
- R4: In the 133 MHz active mode, the memory reference output follows m66_src_i, and memref_src_i has no effect. All other groups behave as in R3.
- R5: In tristate mode, oe_o is 0 and every clock output is low, including both complement outputs.
- R6: A reserved mode behaves as tristate. It also sets illegal_o, which stays high until reset.
- R7: In test mode, the CPU output is the test clock divided by 2, the memory reference output divided by 4 and the PCI output divided by 6, all with 50% duty. The 66 MHz and crystal reference outputs carry the test clock itself. The 48 MHz group is disabled and low, so oe_o is 6'b101111.
- R8: Each test divider restarts low on entry to test mode. After the n-th rising edge in test mode, an output with divide ratio D equals (n / (D/2)) mod 2.
- R9: While its group is enabled, cpu_c_o is the inverse of cpu_t_o and memref_b_o is the inverse of memref_o.
- R10: spread_o is 6'b001111 when ssc_req_ni is low in an active mode, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock; also clocks the select filter |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_fast_i | input | 1 | CPU-rate select (high = 133 MHz setting) |
| freq_bits_i | input | 2 | Frequency select bits |
| ssc_req_ni | input | 1 | Spread request, active low |
| cpu_src_i | input | 1 | CPU group source clock |
| memref_src_i | input | 1 | Half-rate memory reference source |
| m66_src_i | input | 1 | 66 MHz group source |
| pci_src_i | input | 1 | PCI group source |
| f48_src_i | input | 1 | 48 MHz group source |
| xtal_src_i | input | 1 | Crystal reference source |
| cpu_t_o | output | 1 | CPU true output |
| cpu_c_o | output | 1 | CPU complement output |
| memref_o | output | 1 | Memory reference output |
| memref_b_o | output | 1 | Memory reference opposite-phase output |
| m66_o | output | 1 | 66 MHz group output |
| pci_o | output | 1 | PCI group output |
| f48_o | output | 1 | 48 MHz group output |
| xref_o | output | 1 | Crystal reference output |
| oe_o | output | 6 | Per-group output enable |
| spread_o | output | 6 | Per-group spread enable |
| mode_o | output | 3 | Committed mode |
| illegal_o | output | 1 | Sticky reserved-code flag |

## Verification
The checker enforces these on every cycle:
- the complement relation of both pairs while enabled;
- low data on every disabled group;
- the enable pattern in the tristate and test modes;
- the link between a reserved mode and the sticky flag;
- the gating of spread_o;
- that the mode never moves on the cycle after the code changes;
- the CPU divide-by-2 toggling.

Only the bench scenarios can show other properties:
- the exact edge on which a new mode commits;
- the rejection of a one-cycle glitch;
- the choice of memory reference source at each CPU rate;
- the phase sequence of the divide-by-4 and divide-by-6 outputs after each entry to test mode;
- the undivided pass-through of the test clock.

// File: rtl/clkmode_pkg.sv
`timescale 1ns/1ps
package clkmode_pkg;

  localparam int unsigned NGRP = 6;

  localparam int unsigned G_CPU  = 0;
  localparam int unsigned G_MREF = 1;
  localparam int unsigned G_M66  = 2;
  localparam int unsigned G_PCI  = 3;
  localparam int unsigned G_F48  = 4;
  localparam int unsigned G_XREF = 5;

  typedef enum logic [2:0] {
    MD_ACT100 = 3'd0,
    MD_ACT133 = 3'd1,
    MD_TRI    = 3'd2,
    MD_TEST   = 3'd3,
    MD_RSVD   = 3'd4
  } mode_e;

  function automatic mode_e decode_code(input logic [2:0] code);
    case (code)
      3'b000:  return MD_ACT100;
      3'b100:  return MD_ACT133;
      3'b011:  return MD_TRI;
      3'b111:  return MD_TEST;
      default: return MD_RSVD;
    endcase
  endfunction

  function automatic logic is_active(input mode_e m);
    return (m == MD_ACT100) || (m == MD_ACT133);
  endfunction

endpackage

// File: rtl/clkmode_sel_filter.sv
`timescale 1ns/1ps
module clkmode_sel_filter
  import clkmode_pkg::*;
#(
  parameter int unsigned STABLE_CYC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] code_i,
  output mode_e      mode_o,
  output logic       illegal_o
);

  localparam int unsigned CW = (STABLE_CYC < 2) ? 1 : $clog2(STABLE_CYC + 1);

  logic [2:0]    code_q;
  logic [CW-1:0] cnt_q;
  mode_e         mode_q;
  logic          ill_q;
  logic          same;
  logic          commit;
  mode_e         dec;

  assign same   = (code_i == code_q);
  // code_q has matched code_i for STABLE_CYC-1 earlier edges plus this one
  assign commit = same && (cnt_q >= CW'(STABLE_CYC - 1));
  assign dec    = decode_code(code_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      cnt_q  <= '0;
      mode_q <= MD_TRI;
      ill_q  <= 1'b0;
    end else begin
      code_q <= code_i;
      if (!same) begin
        cnt_q <= '0;
      end else if (cnt_q < CW'(STABLE_CYC)) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (commit) begin
        mode_q <= dec;
        if (dec == MD_RSVD) ill_q <= 1'b1;
      end
    end
  end

  assign mode_o    = mode_q;
  assign illegal_o = ill_q;

endmodule

// File: rtl/clkmode_div.sv
`timescale 1ns/1ps
module clkmode_div #(
  parameter int unsigned DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic clk_o
);

  localparam int unsigned HALF = DIV / 2;
  localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (!run_i) begin
      // held cleared outside test mode so every entry starts low and aligned
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (cnt_q == CW'(HALF - 1)) begin
      cnt_q <= '0;
      out_q <= ~out_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign clk_o = out_q;

endmodule

// File: rtl/clkmode_grp_mux.sv
`timescale 1ns/1ps
module clkmode_grp_mux
  import clkmode_pkg::*;
#(
  parameter bit TST_ON = 1'b1
) (
  input  mode_e mode_i,
  input  logic  act_i,
  input  logic  tst_i,
  output logic  dat_o,
  output logic  oe_o
);

  always_comb begin
    dat_o = 1'b0;
    oe_o  = 1'b0;
    case (mode_i)
      MD_ACT100, MD_ACT133: begin
        dat_o = act_i;
        oe_o  = 1'b1;
      end
      MD_TEST: begin
        dat_o = TST_ON ? tst_i : 1'b0;
        oe_o  = TST_ON;
      end
      default: begin
        dat_o = 1'b0;
        oe_o  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/clkmode_ctrl.sv
`timescale 1ns/1ps
module clkmode_ctrl
  import clkmode_pkg::*;
#(
  parameter int unsigned STABLE_CYC = 2,
  parameter int unsigned CPU_TDIV   = 2,
  parameter int unsigned MREF_TDIV  = 4,
  parameter int unsigned PCI_TDIV   = 6,
  parameter logic [5:0]  SSC_MASK   = 6'b001111
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cpu_fast_i,
  input  logic [1:0] freq_bits_i,
  input  logic       ssc_req_ni,
  input  logic       cpu_src_i,
  input  logic       memref_src_i,
  input  logic       m66_src_i,
  input  logic       pci_src_i,
  input  logic       f48_src_i,
  input  logic       xtal_src_i,
  output logic       cpu_t_o,
  output logic       cpu_c_o,
  output logic       memref_o,
  output logic       memref_b_o,
  output logic       m66_o,
  output logic       pci_o,
  output logic       f48_o,
  output logic       xref_o,
  output logic [5:0] oe_o,
  output logic [5:0] spread_o,
  output logic [2:0] mode_o,
  output logic       illegal_o
);

  // 0 = group off in test, 1 = test clock as is, even N = divide by N
  localparam int unsigned TDIV [NGRP] = '{CPU_TDIV, MREF_TDIV, 1, PCI_TDIV, 0, 1};

  mode_e           mode;
  logic [2:0]      code;
  logic            test_run;
  logic            act_mode;
  logic [NGRP-1:0] act_src;
  logic [NGRP-1:0] dat;

  assign code = {cpu_fast_i, freq_bits_i[0], freq_bits_i[1]};

  clkmode_sel_filter #(
    .STABLE_CYC(STABLE_CYC)
  ) u_filt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .code_i   (code),
    .mode_o   (mode),
    .illegal_o(illegal_o)
  );

  assign test_run = (mode == MD_TEST);
  assign act_mode = is_active(mode);

  always_comb begin
    act_src         = '0;
    act_src[G_CPU]  = cpu_src_i;
    act_src[G_MREF] = (mode == MD_ACT133) ? m66_src_i : memref_src_i;
    act_src[G_M66]  = m66_src_i;
    act_src[G_PCI]  = pci_src_i;
    act_src[G_F48]  = f48_src_i;
    act_src[G_XREF] = xtal_src_i;
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int unsigned D = TDIV[g];
    logic tsrc;

    if (D == 0) begin : g_off
      assign tsrc = 1'b0;
    end else if (D == 1) begin : g_thru
      assign tsrc = clk_i;
    end else begin : g_div
      clkmode_div #(
        .DIV(D)
      ) u_div (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .run_i (test_run),
        .clk_o (tsrc)
      );
    end

    clkmode_grp_mux #(
      .TST_ON(D != 0)
    ) u_mux (
      .mode_i(mode),
      .act_i (act_src[g]),
      .tst_i (tsrc),
      .dat_o (dat[g]),
      .oe_o  (oe_o[g])
    );

    assign spread_o[g] = SSC_MASK[g] & act_mode & ~ssc_req_ni;
  end

  assign cpu_t_o    = dat[G_CPU];
  assign cpu_c_o    = oe_o[G_CPU] & ~dat[G_CPU];
  assign memref_o   = dat[G_MREF];
  assign memref_b_o = oe_o[G_MREF] & ~dat[G_MREF];
  assign m66_o      = dat[G_M66];
  assign pci_o      = dat[G_PCI];
  assign f48_o      = dat[G_F48];
  assign xref_o     = dat[G_XREF];
  assign mode_o     = mode;

endmodule

// File: rtl/clkmode_ctrl_chk.sv
`timescale 1ns/1ps
module clkmode_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cpu_fast_i,
  input logic [1:0] freq_bits_i,
  input logic       ssc_req_ni,
  input logic       cpu_t_o,
  input logic       cpu_c_o,
  input logic       memref_o,
  input logic       memref_b_o,
  input logic       m66_o,
  input logic       pci_o,
  input logic       f48_o,
  input logic       xref_o,
  input logic [5:0] oe_o,
  input logic [5:0] spread_o,
  input logic [2:0] mode_o,
  input logic       illegal_o
);

  logic [2:0] code_w;
  logic [5:0] dat_w;
  logic       pv_q;

  assign code_w = {cpu_fast_i, freq_bits_i[0], freq_bits_i[1]};
  assign dat_w  = {xref_o, f48_o, pci_o, m66_o, memref_o, cpu_t_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pv_q <= 1'b0;
    else         pv_q <= 1'b1;
  end

  p_mode_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pv_q && !$stable(code_w)) |=> $stable(mode_o));

  p_tri_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd2) |-> (oe_o == 6'd0));

  p_off_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dat_w & ~oe_o) == 6'd0));

  p_rsvd_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd4) |-> illegal_o);

  p_flag_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> illegal_o);

  p_test_oe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd3) |-> (oe_o == 6'b101111));

  p_cpu_div2_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pv_q && mode_o == 3'd3 && $past(mode_o) == 3'd3) |-> (cpu_t_o != $past(cpu_t_o)));

  p_cpu_pair_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o[0] |-> (cpu_c_o != cpu_t_o));

  p_mref_pair_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o[1] |-> (memref_b_o != memref_o));

  p_ssc_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ssc_req_ni |-> (spread_o == 6'd0));

  p_ssc_mode_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o > 3'd1) |-> (spread_o == 6'd0));

endmodule

bind clkmode_ctrl clkmode_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cpu_fast_i (cpu_fast_i),
  .freq_bits_i(freq_bits_i),
  .ssc_req_ni (ssc_req_ni),
  .cpu_t_o    (cpu_t_o),
  .cpu_c_o    (cpu_c_o),
  .memref_o   (memref_o),
  .memref_b_o (memref_b_o),
  .m66_o      (m66_o),
  .pci_o      (pci_o),
  .f48_o      (f48_o),
  .xref_o     (xref_o),
  .oe_o       (oe_o),
  .spread_o   (spread_o),
  .mode_o     (mode_o),
  .illegal_o  (illegal_o)
);

// File: tb/tb_clkmode_ctrl.sv
`timescale 1ns/1ps
module tb_clkmode_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] code = 3'b000;
  logic       ssc_n = 1'b1;
  logic [5:0] src = 6'd0;

  logic cpu_t, cpu_c, mref, mref_b, m66, pci, f48, xref, ill;
  logic [5:0] oe, spr;
  logic [2:0] mode;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  clkmode_ctrl dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cpu_fast_i  (code[2]),
    .freq_bits_i ({code[0], code[1]}),
    .ssc_req_ni  (ssc_n),
    .cpu_src_i   (src[0]),
    .memref_src_i(src[1]),
    .m66_src_i   (src[2]),
    .pci_src_i   (src[3]),
    .f48_src_i   (src[4]),
    .xtal_src_i  (src[5]),
    .cpu_t_o     (cpu_t),
    .cpu_c_o     (cpu_c),
    .memref_o    (mref),
    .memref_b_o  (mref_b),
    .m66_o       (m66),
    .pci_o       (pci),
    .f48_o       (f48),
    .xref_o      (xref),
    .oe_o        (oe),
    .spread_o    (spr),
    .mode_o      (mode),
    .illegal_o   (ill)
  );

  wire [7:0] dat = {xref, f48, pci, m66, mref_b, mref, cpu_c, cpu_t};

  typedef struct packed {
    logic [2:0] code;
    logic       ssc_n;
    logic [5:0] src;   // bit = group index
    logic [2:0] mode;
    logic [5:0] oe;
    logic [7:0] dat;   // {xref,f48,pci,m66,mref_b,mref,cpu_c,cpu_t}
    logic [5:0] spr;
    logic       ill;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{3'b000, 1'b1, 6'b101101, 3'd0, 6'h3f, 8'b10111001, 6'h00, 1'b0},
    '{3'b000, 1'b0, 6'b010010, 3'd0, 6'h3f, 8'b01000110, 6'h0f, 1'b0},
    '{3'b100, 1'b0, 6'b000110, 3'd1, 6'h3f, 8'b00010110, 6'h0f, 1'b0},
    '{3'b100, 1'b1, 6'b000010, 3'd1, 6'h3f, 8'b00001010, 6'h00, 1'b0},
    '{3'b011, 1'b0, 6'b111111, 3'd2, 6'h00, 8'b00000000, 6'h00, 1'b0},
    '{3'b001, 1'b0, 6'b111111, 3'd4, 6'h00, 8'b00000000, 6'h00, 1'b1},
    '{3'b000, 1'b1, 6'b010101, 3'd0, 6'h3f, 8'b01011001, 6'h00, 1'b1}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // enter test mode from a stable mode prev; check commit edge and divider phases
  task automatic test_run(input logic [2:0] prev, input int cycles);
    code = 3'b111;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R2", "mode before commit", 32'(mode), 32'(prev));
    @(posedge clk);
    @(negedge clk);
    chk("R1", "test mode code", 32'(mode), 32'd3);
    chk("R7", "test oe", 32'(oe), 32'h2f);
    chk("R8", "dividers low at entry", {29'd0, cpu_t, mref, pci}, 32'd0);
    for (int n = 1; n <= cycles; n++) begin
      @(posedge clk);
      #1;
      chk("R7", "m66 passes test clock high", 32'(m66), 32'd1);
      chk("R7", "xref passes test clock high", 32'(xref), 32'd1);
      @(negedge clk);
      chk("R8", "div2 phase", 32'(cpu_t), 32'((n / 1) % 2));
      chk("R8", "div4 phase", 32'(mref), 32'((n / 2) % 2));
      chk("R8", "div6 phase", 32'(pci), 32'((n / 3) % 2));
      chk("R9", "cpu complement", 32'(cpu_c), 32'(!cpu_t));
      chk("R9", "mref complement", 32'(mref_b), 32'(!mref));
      chk("R7", "m66 low phase", 32'(m66), 32'd0);
      chk("R7", "f48 held low", 32'(f48), 32'd0);
      chk("R10", "no spread in test", 32'(spr), 32'd0);
    end
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    ssc_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "reset mode", 32'(mode), 32'd2);
    chk("R5", "reset oe", 32'(oe), 32'd0);
    chk("R6", "reset illegal flag", 32'(ill), 32'd0);
    chk("R10", "reset spread", 32'(spr), 32'd0);
    rst_n = 1'b1;
    ssc_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1", "first commit", 32'(mode), 32'd0);

    for (int i = 0; i < NV; i++) begin
      code  = VECS[i].code;
      ssc_n = VECS[i].ssc_n;
      src   = VECS[i].src;
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R1", "vector mode", 32'(mode), 32'(VECS[i].mode));
      chk("R3", "vector oe", 32'(oe), 32'(VECS[i].oe));
      chk("R4", "vector data", 32'(dat), 32'(VECS[i].dat));
      chk("R10", "vector spread", 32'(spr), 32'(VECS[i].spr));
      chk("R6", "vector illegal flag", 32'(ill), 32'(VECS[i].ill));
    end

    // R2: one-cycle glitch to tristate is rejected
    code = 3'b011;
    @(posedge clk);
    @(negedge clk);
    code = 3'b000;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R2", "glitch ignored mode", 32'(mode), 32'd0);
    chk("R2", "glitch ignored oe", 32'(oe), 32'h3f);

    // R2: exact commit edge for tristate
    code = 3'b011;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R2", "two edges no commit", 32'(mode), 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R2", "third edge commit", 32'(mode), 32'd2);
    chk("R5", "tristate data low", 32'(dat), 32'd0);

    // test mode, leave mid-phase, re-enter
    test_run(3'd2, 13);
    code = 3'b000;
    src  = 6'b000001;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R3", "back to active", 32'(mode), 32'd0);
    chk("R3", "cpu follows source", 32'(cpu_t), 32'd1);
    test_run(3'd0, 12);

    // reset clears sticky flag
    code = 3'b110;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R6", "reserved 110 sets flag", 32'(ill), 32'd1);
    chk("R1", "reserved 110 mode", 32'(mode), 32'd4);
    rst_n = 1'b0;
    #1;
    chk("R6", "reset clears flag", 32'(ill), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule